// File: doc/BRIEF.md
# Real-Time Seconds Counter with Staged Configuration

This block keeps time across two clock domains. A small register port on the peripheral clock gives software access. The timekeeping core runs on a slow real-time clock and has its own reset that stays on. The core divides the slow clock with a programmable prescaler and counts whole seconds in a 32-bit counter. It compares that counter with an alarm value. It raises three sticky events: second, alarm and overflow. Each event has its own interrupt enable.

Software cannot write the core's prescaler, counter or alarm directly. An external unlock input must first be high. Then a configuration window must be opened in the control register. Writes made inside the window are held in staging registers on the bus side. Closing the window launches a toggle handshake into the slow domain. The core applies only the registers that were written. A done flag in the control register stays low until the core's acknowledge has come back through a synchronizer. While that flag is low, a new window cannot be opened.

Register map, as the byte-free word address `busAddr`:

| Address | Register | Bits |
|---|---|---|
| 0 | control | bit0 config window; bit1 second enable; bit2 alarm enable; bit3 overflow enable; bit4 done (read only) |
| 1 | events | bit0 second; bit1 alarm; bit2 overflow |
| 2 | prescaler reload | 20 bits |
| 3 | seconds counter | 32 bits |
| 4 | alarm compare | 32 bits |
| 5 | prescaler down-counter | 20 bits, read only |

Top module: `rtc_timekeeper`

## Requirements
- R1: After both resets, the registers read as follows: control 0x10 (done high, all else low), events 0, counter 0, prescaler 0x7FFF, alarm 0xFFFFFFFF. `irq` is low.
- R2: While `wrUnlock` is low, every bus write has no effect. This covers the control register (address 0) and the counter register (address 3).
- R3: With the unlock high but the config window (control bit0) closed, writes to prescaler, counter and alarm (addresses 2, 3, 4) have no effect.
- R4: Closing the window drops done (control bit4) in the next bus cycle. Done rises again only after at least three slow-clock edges. Then only the registers written inside the window hold their new values; the others keep counting or keep their values.
- R5: Setting control bit0 while done is low leaves the window closed.
- R6: With a reload value N, the counter advances by exactly one every N+1 slow-clock cycles. The down-counter (address 5) always reads within 0..N.
- R7: Each counter advance sets the second event (bit0 of address 1).
- R8: When the counter steps onto the alarm value, the alarm event (bit1) sets.
- R9: `irq` is high exactly when some event is set together with its enable. The pairs are: second with control bit1, alarm with bit2, overflow with bit3.
- R10: Writing 0 to an event bit at address 1 clears that event. Writing 1 leaves it as it is.
- R11: A counter advance from 0xFFFFFFFF wraps the counter to 0 and sets the overflow event (bit2).
- R12: A system reset alone returns the control register to 0x10. The prescaler, counter and alarm are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| sysRstN | input | 1 | Active-low asynchronous system reset, bus domain |
| rtcClk | input | 1 | Slow real-time clock |
| rtcRstN | input | 1 | Active-low always-on domain reset |
| wrUnlock | input | 1 | Backup write enable; writes are ignored while low |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | High for a write, low for a read |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | OR of enabled events |

## Verification
The commit path is tried with three window contents. The first writes all three registers. The second writes the counter alone, close to its wrap. The third writes only the alarm. This separates a core that applies every staged value from one that honours the written-register mask. The counting path is checked with a small reload value by measuring the slow-clock edges between two counter steps. This separates an N+1 divider from an N or N+2 one. Writes that are locked, made outside the window, or made during a transfer are each followed by a readback. Each readback shows whether the write leaked through. Interrupts are checked with enables both off and on, and after a selective clear. This shows that the event bits are ANDed with their own enables.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;
  localparam int CNT_W  = 32;
  localparam int PRE_W  = 20;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int FLAG_N = 3;

  // event bit positions (shared by status, enables and clear masks)
  localparam int FL_SEC = 0;
  localparam int FL_ALM = 1;
  localparam int FL_OVF = 2;

  // written-register mask bit positions
  localparam int M_PRE = 0;
  localparam int M_CNT = 1;
  localparam int M_ALM = 2;

  // control register layout
  localparam int C_MODE    = 0;
  localparam int C_IE_LSB  = 1;
  localparam int C_DONE    = C_IE_LSB + FLAG_N;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd5;

  // bus domain -> slow domain: toggles plus quasi-static payload
  typedef struct packed {
    logic              cfgTog;
    logic [2:0]        wrMask;
    logic [PRE_W-1:0]  stPre;
    logic [CNT_W-1:0]  stCnt;
    logic [CNT_W-1:0]  stAlm;
    logic              clrTog;
    logic [FLAG_N-1:0] clrMask;
  } xferReq_t;

  // slow domain -> bus domain: acknowledges plus observed state
  typedef struct packed {
    logic              cfgAck;
    logic              clrAck;
    logic [FLAG_N-1:0] flags;
    logic [CNT_W-1:0]  cnt;
    logic [PRE_W-1:0]  pre;
    logic [CNT_W-1:0]  alm;
    logic [PRE_W-1:0]  divCnt;
  } coreStat_t;
endpackage

// File: rtl/rtc_tk_ctrl.sv
module rtc_tk_ctrl
  import rtc_tk_pkg::*;
(
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              wrUnlock,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output xferReq_t          req,
  input  coreStat_t         stat
);
  coreStat_t         statS1, statS2;
  logic              cfgMode;
  logic [FLAG_N-1:0] ie;
  logic [FLAG_N-1:0] pendClr;
  logic [FLAG_N-1:0] pendNext;
  logic              cfgDone, clrBusy;
  logic              wrEn, ctrlWr, stageWr, flagWr;

  // two-flop synchronizer for everything coming back from the slow domain
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      statS1 <= '0;
      statS2 <= '0;
    end else begin
      statS1 <= stat;
      statS2 <= statS1;
    end
  end

  assign cfgDone = (statS2.cfgAck == req.cfgTog);
  assign clrBusy = (statS2.clrAck != req.clrTog);
  assign wrEn    = busValid && busWrite && wrUnlock;
  assign ctrlWr  = wrEn && (busAddr == A_CTRL);
  assign flagWr  = wrEn && (busAddr == A_FLAG);
  assign stageWr = wrEn && cfgMode && cfgDone;
  assign pendNext = pendClr | (flagWr ? ~busWdata[FLAG_N-1:0] : '0);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      cfgMode <= 1'b0;
      ie      <= '0;
      pendClr <= '0;
      req     <= '0;
    end else begin
      if (ctrlWr) begin
        ie <= busWdata[C_IE_LSB +: FLAG_N];
        if (cfgMode && !busWdata[C_MODE]) begin
          cfgMode    <= 1'b0;
          req.cfgTog <= ~req.cfgTog;
        end else if (!cfgMode && busWdata[C_MODE] && cfgDone) begin
          cfgMode    <= 1'b1;
          req.wrMask <= '0;
        end
      end
      if (stageWr) begin
        case (busAddr)
          A_PRE: begin req.stPre <= busWdata[PRE_W-1:0]; req.wrMask[M_PRE] <= 1'b1; end
          A_CNT: begin req.stCnt <= busWdata;            req.wrMask[M_CNT] <= 1'b1; end
          A_ALM: begin req.stAlm <= busWdata;            req.wrMask[M_ALM] <= 1'b1; end
          default: ;
        endcase
      end
      if (!clrBusy && (pendNext != '0)) begin
        req.clrMask <= pendNext;
        req.clrTog  <= ~req.clrTog;
        pendClr     <= '0;
      end else begin
        pendClr <= pendNext;
      end
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) irq <= 1'b0;
    else          irq <= |(statS2.flags & ie);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL: begin
        busRdata[C_MODE]               = cfgMode;
        busRdata[C_IE_LSB +: FLAG_N]   = ie;
        busRdata[C_DONE]               = cfgDone;
      end
      A_FLAG: busRdata[FLAG_N-1:0] = statS2.flags;
      A_PRE:  busRdata[PRE_W-1:0]  = statS2.pre;
      A_CNT:  busRdata             = statS2.cnt;
      A_ALM:  busRdata             = statS2.alm;
      A_DIV:  busRdata[PRE_W-1:0]  = statS2.divCnt;
      default: busRdata = '0;
    endcase
  end

  // R2: locked writes leave control state alone
  p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    (busValid && busWrite && !wrUnlock) |=> ($stable(cfgMode) && $stable(ie)));

  // R4: closing the window drops done on the next cycle
  p_exit_busy_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    (ctrlWr && cfgMode && !busWdata[C_MODE]) |=> !cfgDone);

  // R4: staged payload frozen while a transfer is in flight
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    !cfgDone |=> ($stable(req.wrMask) && $stable(req.stCnt) &&
                  $stable(req.stPre) && $stable(req.stAlm)));

  // R5: never inside a window while a transfer is pending
  p_no_entry_busy_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    !cfgDone |-> !cfgMode);
endmodule

// File: rtl/rtc_tk_core.sv
module rtc_tk_core
  import rtc_tk_pkg::*;
#(
  parameter logic [PRE_W-1:0] PRE_RST = 20'h07FFF
) (
  input  logic      rtcClk,
  input  logic      rtcRstN,
  input  xferReq_t  req,
  output coreStat_t stat
);
  logic [2:0]        cfgS, clrS;
  logic [PRE_W-1:0]  pre, divCnt, preNext;
  logic [CNT_W-1:0]  cnt, alm, cntInc;
  logic [FLAG_N-1:0] flags, setMask, clrApply;
  logic              loadNow, clrNow, reloadDiv, tick;

  // toggle synchronizers; third stage both detects the edge and acknowledges
  always_ff @(posedge rtcClk or negedge rtcRstN) begin
    if (!rtcRstN) begin
      cfgS <= '0;
      clrS <= '0;
    end else begin
      cfgS <= {cfgS[1:0], req.cfgTog};
      clrS <= {clrS[1:0], req.clrTog};
    end
  end

  assign loadNow   = cfgS[2] ^ cfgS[1];
  assign clrNow    = clrS[2] ^ clrS[1];
  assign reloadDiv = loadNow && (req.wrMask[M_PRE] || req.wrMask[M_CNT]);
  assign preNext   = (loadNow && req.wrMask[M_PRE]) ? req.stPre : pre;
  assign tick      = !reloadDiv && (divCnt == '0);
  assign cntInc    = cnt + 1'b1;
  assign clrApply  = clrNow ? req.clrMask : '0;

  always_comb begin
    setMask = '0;
    setMask[FL_SEC] = tick;
    setMask[FL_ALM] = tick && (cntInc == alm);
    setMask[FL_OVF] = tick && (cnt == '1);
  end

  always_ff @(posedge rtcClk or negedge rtcRstN) begin
    if (!rtcRstN) begin
      pre    <= PRE_RST;
      divCnt <= PRE_RST;
      cnt    <= '0;
      alm    <= '1;
      flags  <= '0;
    end else begin
      pre <= preNext;
      if (loadNow && req.wrMask[M_ALM]) alm <= req.stAlm;
      if (reloadDiv)  divCnt <= preNext;
      else if (tick)  divCnt <= pre;
      else            divCnt <= divCnt - 1'b1;
      if (loadNow && req.wrMask[M_CNT]) cnt <= req.stCnt;
      else if (tick)                    cnt <= cntInc;
      flags <= (flags & ~clrApply) | setMask;
    end
  end

  always_comb begin
    stat.cfgAck = cfgS[2];
    stat.clrAck = clrS[2];
    stat.flags  = flags;
    stat.cnt    = cnt;
    stat.pre    = pre;
    stat.alm    = alm;
    stat.divCnt = divCnt;
  end

  // R6: counter holds between ticks
  p_hold_between_ticks_r6: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    (!loadNow && divCnt != '0) |=> (cnt == $past(cnt)));

  // R7: every tick leaves the second event set
  p_second_set_r7: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    (!reloadDiv && divCnt == '0) |=> flags[FL_SEC]);

  // R11: wrap goes to zero with overflow raised
  p_no_overflow_r11: assert property (@(posedge rtcClk) disable iff (!rtcRstN)
    (!reloadDiv && divCnt == '0 && cnt == '1) |=> (cnt == '0 && flags[FL_OVF]));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_tk_pkg::*;
#(
  parameter logic [PRE_W-1:0] PRE_RST = 20'h07FFF
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              rtcClk,
  input  logic              rtcRstN,
  input  logic              wrUnlock,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  xferReq_t  req;
  coreStat_t stat;

  rtc_tk_ctrl u_ctrl (
    .clk      (clk),
    .sysRstN  (sysRstN),
    .wrUnlock (wrUnlock),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .req      (req),
    .stat     (stat)
  );

  rtc_tk_core #(.PRE_RST(PRE_RST)) u_core (
    .rtcClk  (rtcClk),
    .rtcRstN (rtcRstN),
    .req     (req),
    .stat    (stat)
  );
endmodule

// File: tb/rtc_timekeeper_bench.sv
module rtc_timekeeper_bench;
  logic        clk = 1'b0, rtcClk = 1'b0;
  logic        sysRstN = 1'b0, rtcRstN = 1'b0, wrUnlock = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        irq;
  int          vecs = 0, errs = 0, rtcEdges = 0;
  bit          finished = 1'b0;

  always #2  clk    = ~clk;
  always #20 rtcClk = ~rtcClk;
  always @(posedge rtcClk) rtcEdges <= rtcEdges + 1;

  rtc_timekeeper u_rtc_timekeeper (
    .clk(clk), .sysRstN(sysRstN), .rtcClk(rtcClk), .rtcRstN(rtcRstN),
    .wrUnlock(wrUnlock), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    v = 32'd0;
    while (!v[4]) rd(3'd0, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 control", v == 32'h10, v, 32'h10);
    rd(3'd1, v); chk("R1 events", v == 32'h0, v, 32'h0);
    rd(3'd3, v); chk("R1 counter", v == 32'h0, v, 32'h0);
    rd(3'd2, v); chk("R1 prescaler", v == 32'h7FFF, v, 32'h7FFF);
    rd(3'd4, v); chk("R1 alarm", v == 32'hFFFFFFFF, v, 32'hFFFFFFFF);
    chk("R1 irq", irq == 1'b0, {31'd0, irq}, 32'd0);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wrUnlock = 1'b0;
    wr(3'd0, 32'h0F);
    wr(3'd3, 32'h55);
    idle(60);
    rd(3'd0, v); chk("R2 locked control", v == 32'h10, v, 32'h10);
    rd(3'd3, v); chk("R2 locked counter", v == 32'h0, v, 32'h0);
  endtask

  task automatic t_outside();
    logic [31:0] v;
    wrUnlock = 1'b1;
    wr(3'd3, 32'h77);
    wr(3'd2, 32'h5);
    idle(60);
    rd(3'd3, v); chk("R3 counter outside window", v == 32'h0, v, 32'h0);
    rd(3'd2, v); chk("R3 prescaler outside window", v == 32'h7FFF, v, 32'h7FFF);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    int e0;
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R4 window open", v == 32'h11, v, 32'h11);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd100);
    wr(3'd4, 32'd103);
    wr(3'd0, 32'h0);
    e0 = rtcEdges;
    rd(3'd0, v); chk("R4 done low after exit", v[4] == 1'b0, {31'd0, v[4]}, 32'd0);
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R5 entry refused while busy", v[0] == 1'b0, {31'd0, v[0]}, 32'd0);
    waitDone();
    chk("R4 commit latency in slow edges", (rtcEdges - e0) >= 3, rtcEdges - e0, 32'd3);
    rd(3'd0, v); chk("R5 window still closed", v[0] == 1'b0, {31'd0, v[0]}, 32'd0);
    rd(3'd2, v); chk("R4 prescaler committed", v == 32'd3, v, 32'd3);
    rd(3'd4, v); chk("R4 alarm committed", v == 32'd103, v, 32'd103);
    rd(3'd3, v); chk("R4 counter committed", v >= 32'd100 && v <= 32'd101, v, 32'd100);
  endtask

  task automatic t_tick();
    logic [31:0] v0, v1, v2, d;
    int e0, e1;
    rd(3'd3, v0);
    v1 = v0;
    while (v1 == v0) rd(3'd3, v1);
    e0 = rtcEdges;
    v2 = v1;
    while (v2 == v1) rd(3'd3, v2);
    e1 = rtcEdges;
    chk("R6 tick period", (e1 - e0) == 4, e1 - e0, 32'd4);
    chk("R6 step of one", v2 == v1 + 1, v2, v1 + 1);
    rd(3'd5, d); chk("R6 divider range", d <= 32'd3, d, 32'd3);
    rd(3'd1, d); chk("R7 second event", d[0] == 1'b1, {31'd0, d[0]}, 32'd1);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    v = 32'd0;
    while (v < 32'd104) rd(3'd3, v);
    rd(3'd1, v); chk("R8 alarm event at 103", v[1] == 1'b1, {31'd0, v[1]}, 32'd1);
    chk("R9 irq off with no enables", irq == 1'b0, {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h4);
    idle(4);
    chk("R9 irq with alarm enable", irq == 1'b1, {31'd0, irq}, 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd1, 32'h5);
    idle(80);
    rd(3'd1, v); chk("R10 alarm cleared", v[1] == 1'b0, {31'd0, v[1]}, 32'd0);
    chk("R10 irq drops", irq == 1'b0, {31'd0, irq}, 32'd0);
    chk("R10 second kept", v[0] == 1'b1, {31'd0, v[0]}, 32'd1);
    wr(3'd0, 32'h2);
    idle(4);
    chk("R9 irq with second enable", irq == 1'b1, {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    wr(3'd3, 32'hFFFFFFFF);
    wr(3'd0, 32'h0);
    waitDone();
    idle(60);
    rd(3'd3, v); chk("R11 counter wrapped", v < 32'd4, v, 32'd0);
    rd(3'd1, v); chk("R11 overflow event", v[2] == 1'b1, {31'd0, v[2]}, 32'd1);
    rd(3'd2, v); chk("R4 unwritten prescaler kept", v == 32'd3, v, 32'd3);
  endtask

  task automatic t_alarmOnly();
    logic [31:0] c0, v;
    rd(3'd3, c0);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'h0);
    waitDone();
    rd(3'd4, v); chk("R4 alarm only committed", v == 32'd7, v, 32'd7);
    rd(3'd3, v); chk("R4 counter not reloaded", v >= c0 && v < c0 + 5, v, c0);
    while (v < 32'd8) rd(3'd3, v);
    rd(3'd1, v); chk("R8 alarm event at 7", v[1] == 1'b1, {31'd0, v[1]}, 32'd1);
  endtask

  task automatic t_sysReset();
    logic [31:0] v;
    wr(3'd0, 32'h2);
    @(negedge clk); sysRstN = 1'b0;
    idle(3);
    sysRstN = 1'b1;
    idle(100);
    rd(3'd0, v); chk("R12 control after system reset", v == 32'h10, v, 32'h10);
    chk("R12 irq after system reset", irq == 1'b0, {31'd0, irq}, 32'd0);
    rd(3'd2, v); chk("R12 prescaler kept", v == 32'd3, v, 32'd3);
    rd(3'd4, v); chk("R12 alarm kept", v == 32'd7, v, 32'd7);
    rd(3'd3, v); chk("R12 counter kept", v >= 32'd8, v, 32'd8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #98;
    sysRstN = 1'b1;
    rtcRstN = 1'b1;
    idle(10);
    t_reset();
    t_locked();
    t_outside();
    t_commit();
    t_tick();
    t_alarm();
    t_clear();
    t_ovf();
    t_alarmOnly();
    t_sysReset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule